// File: doc/BRIEF.md
# Counter-Driven Pulse Width Modulator

This block turns a 4-bit duty value into a single-bit pulse train with a fixed period of 16 clock cycles. In each period the pulse is high for exactly as many cycles as the duty value, starting at the first cycle of the period, and low for the rest. The producer of the duty value is expected to present a new value every 16 clock edges, aligned to the start of a period.

A free-running phase counter, reset to zero, advances by one on every clock edge and wraps from 15 back to 0. The output is a plain magnitude compare of that phase against the duty input. No flop follows the compare, so a duty change reaches the output in the same cycle. The phase is stored in a general-purpose enabled register whose synchronous reset loads a value taken from an input port. This block ties that port to zero and holds the enable high.

Top module: `duty_pwm`

## Requirements
- R1: Over any 16-cycle period that starts at phase 0 with a steady duty value N (0 to 15), the pulse output is high for exactly N cycles.
- R2: In each period the pulse is high in phase slots 0 to N-1 and low in slots N to 15. The high cycles come first.
- R3: The pulse is formed combinationally from the current phase and the current duty input. A duty change mid-period changes the output within the same clock cycle.
- R4: After synchronous reset the phase is 0. It advances by 1 on every non-reset clock edge and wraps from 15 to 0, so every period is 16 cycles. A reset applied mid-period restarts the period.
- R5: The enabled register's synchronous reset loads the value on its seed input, whether or not its enable is asserted.
- R6: When its enable is low and reset is not asserted, the enabled register holds its value. When its enable is high, it loads its data input on the next edge.
- R7: The enabled register's width is a parameter with a default of 8 bits.
- R8: A duty value of 0 keeps the pulse low for the whole period. A duty value of 15 gives 15 high cycles, then one low cycle in slot 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; returns the phase to 0 |
| duty | input | 4 | Number of high cycles per 16-cycle period |
| pulse | output | 1 | Modulated output, combinational from phase and duty |

## Verification
The pulse is a same-cycle function of the phase and the duty input. The bench therefore changes the duty value just after a falling edge and samples the pulse one nanosecond later, before the next rising edge can move the phase. The phase itself moves one rising edge after each step, and one rising edge after reset is asserted. Each sample is therefore tagged with the slot it falls in, counting from the falling edge on which reset was released, where the phase is 0. The stand-alone register checks drive inputs on a falling edge and read the output at the next falling edge, one rising edge later.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // Default width of the duty input and phase counter.
   localparam int unsigned PWM_DUTY_W = 4;
   // Default width of the general-purpose enabled register.
   localparam int unsigned SEED_REG_W = 8;
endpackage

// File: rtl/pwm_seed_reg.sv
module pwm_seed_reg #(
   parameter int unsigned WIDTH = pwm_pkg::SEED_REG_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] seed,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pwm_seed_reg: WIDTH must be at least 1");
      end
   endgenerate

   // Reset loads the seed port and takes priority over enable.
   always_ff @(posedge clk) begin
      if (rst)
         q <= seed;
      else if (en)
         q <= d;
   end

   // R5: the first cycle out of reset shows the seed seen at the last reset edge
   p_seed_on_reset_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> q == $past(seed));

   // R6: an idle enable keeps the stored value
   p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
      !en |=> q == $past(q));

   // R6: an active enable captures the data input
   p_load_when_enabled_r6: assert property (@(posedge clk) disable iff (rst)
      en |=> q == $past(d));
endmodule

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
   parameter int unsigned WIDTH = pwm_pkg::PWM_DUTY_W
) (
   input  logic             clk,
   input  logic             rst,
   output logic [WIDTH-1:0] phase
);
   localparam logic [WIDTH-1:0] ZERO = '0;
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   generate
      if (WIDTH < 2 || WIDTH > 16) begin : g_bad_width
         $error("pwm_phase_counter: WIDTH must lie in 2..16");
      end
   endgenerate

   logic [WIDTH-1:0] next_phase;

   // Natural binary wrap gives a period of 2**WIDTH cycles.
   always_comb next_phase = phase + STEP;

   pwm_seed_reg #(.WIDTH(WIDTH)) u_phase_reg (
      .clk  (clk),
      .rst  (rst),
      .en   (1'b1),
      .seed (ZERO),
      .d    (next_phase),
      .q    (phase)
   );

   // R4: the phase is zero on the first cycle after reset
   p_zero_after_reset_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> phase == ZERO);

   // R4: the phase steps by one per cycle and wraps at the top
   p_wrap_step_r4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> phase == $past(phase) + STEP);
endmodule

// File: rtl/pwm_level_cmp.sv
module pwm_level_cmp #(
   parameter int unsigned WIDTH = pwm_pkg::PWM_DUTY_W
) (
   input  logic [WIDTH-1:0] phase,
   input  logic [WIDTH-1:0] level,
   output logic             above
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pwm_level_cmp: WIDTH must be at least 1");
      end
   endgenerate

   // Pure compare: no register stage after it.
   always_comb above = (phase < level);
endmodule

// File: rtl/duty_pwm.sv
module duty_pwm #(
   parameter int unsigned DUTY_W = pwm_pkg::PWM_DUTY_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DUTY_W-1:0] duty,
   output logic              pulse
);
   localparam logic [DUTY_W-1:0] LAST_SLOT = '1;

   logic [DUTY_W-1:0] phase;

   pwm_phase_counter #(.WIDTH(DUTY_W)) u_phase (
      .clk   (clk),
      .rst   (rst),
      .phase (phase)
   );

   pwm_level_cmp #(.WIDTH(DUTY_W)) u_cmp (
      .phase (phase),
      .level (duty),
      .above (pulse)
   );

   // R8: a zero duty never raises the pulse
   p_zero_duty_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      duty == '0 |-> !pulse);

   // R8: the last slot of a period is always low
   p_last_slot_low_r8: assert property (@(posedge clk) disable iff (rst)
      phase == LAST_SLOT |-> !pulse);

   // R2: slot 0 is high whenever the duty is non-zero
   p_first_slot_high_r2: assert property (@(posedge clk) disable iff (rst)
      (phase == '0 && duty != '0) |-> pulse);
endmodule

// File: tb/duty_pwm_bench.sv
module duty_pwm_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] duty = '0;
   logic       pulse;

   logic       r_rst = 1'b1;
   logic       r_en = 1'b0;
   logic [7:0] r_seed = 8'h00;
   logic [7:0] r_d = 8'h00;
   logic [7:0] r_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   duty_pwm u_duty_pwm (
      .clk   (clk),
      .rst   (rst),
      .duty  (duty),
      .pulse (pulse)
   );

   pwm_seed_reg u_seed_reg (
      .clk  (clk),
      .rst  (r_rst),
      .en   (r_en),
      .seed (r_seed),
      .d    (r_d),
      .q    (r_q)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Entered at a falling edge where the phase is 0; leaves at the next such edge.
   task automatic run_window(input int n);
      int highs = 0;
      duty = 4'(n);
      for (int k = 0; k < 16; k++) begin
         #1;
         check(pulse == (k < n), "R2 slot level", int'(pulse), int'(k < n));
         if (pulse) highs++;
         @(negedge clk);
      end
      check(highs == n, (n == 0 || n == 15) ? "R8 edge duty count" : "R1 high count", highs, n);
   endtask

   initial begin
      // Register checks (R5, R6, R7)
      check($bits(r_q) == 8 && $bits(u_seed_reg.q) == 8, "R7 default width", $bits(u_seed_reg.q), 8);
      @(negedge clk);
      r_rst = 1'b1; r_en = 1'b0; r_seed = 8'hA5; r_d = 8'h11;
      @(negedge clk);
      check(r_q == 8'hA5, "R5 reset with enable low", r_q, 8'hA5);
      r_rst = 1'b0; r_en = 1'b1; r_d = 8'h3C;
      @(negedge clk);
      check(r_q == 8'h3C, "R6 enabled load", r_q, 8'h3C);
      r_en = 1'b0; r_d = 8'hFF;
      @(negedge clk);
      @(negedge clk);
      check(r_q == 8'h3C, "R6 hold while idle", r_q, 8'h3C);
      r_rst = 1'b1; r_en = 1'b1; r_d = 8'h11; r_seed = 8'h5A;
      @(negedge clk);
      check(r_q == 8'h5A, "R5 reset with enable high", r_q, 8'h5A);
      r_rst = 1'b0;

      // PWM: reset state, phase 0 on release (R4)
      duty = 4'd1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check(pulse == 1'b1, "R4 phase zero after reset", int'(pulse), 1);
      #1;
      @(negedge clk);
      #1;
      check(pulse == 1'b0, "R4 phase advanced past zero", int'(pulse), 0);
      repeat (15) @(negedge clk);

      // Full sweep of duty values (R1, R2, R8)
      for (int n = 0; n < 16; n++) run_window(n);
      run_window(15);
      run_window(0);
      run_window(7);

      // Combinational response mid-period (R3)
      duty = 4'd8;
      repeat (5) @(negedge clk);
      duty = 4'd3;
      #1;
      check(pulse == 1'b0, "R3 same-cycle drop", int'(pulse), 0);
      duty = 4'd10;
      #1;
      check(pulse == 1'b1, "R3 same-cycle rise", int'(pulse), 1);
      repeat (11) @(negedge clk);

      // Mid-period reset restarts the period (R4)
      duty = 4'd2;
      repeat (7) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      run_window(2);
      run_window(9);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule